// File: doc/BRIEF.md
# Memory Reset and Ready Sequencer

This block sits between the reset pin of a parallel NOR-style memory model and the logic that serves host accesses. It samples the active-low device reset pin on every clock edge. A low level counts as a real reset only after it has lasted a minimum number of cycles. Once a reset is accepted, the block aborts any embedded program or erase that is running. It holds the command decoder in array-read mode and keeps the data pins and the command path closed.

Readiness is reported on an open-drain style ready/busy output. The time until the internal reset completes depends on whether an embedded operation was running when the reset was accepted. If one was running, the output is held busy for that whole time. If the device was idle, the output stays ready. In both cases, host reads and writes reopen only after two conditions hold: the internal reset has completed, and the reset pin has been seen high for a recovery period. All timings are clock-cycle parameters. The reset pin is assumed to be synchronous to the clock already.

Top module: `mem_rst_seq`

## Requirements
- R1: A device reset is accepted at the T_RP-th consecutive clock edge that samples `mem_rst_n` low. A low pulse of T_RP-1 samples or fewer is ignored. It raises no `op_aborted` pulse, leaves `force_rd` low, and leaves `ry_by` equal to the inverse of `eng_busy`. Commands are accepted again at the first edge after the pin returns high.
- R2: While `mem_rst_n` is low, `dq_oe`, `cmd_we` and `cmd_accept` are all 0 in the same cycle, whether or not the reset has been accepted yet.
- R3: If `eng_busy` is 1 at the edge that accepts a reset, `op_aborted` is 1 for exactly the one cycle after that edge. If `eng_busy` is 0 at that edge, `op_aborted` stays 0.
- R4: Outside an accepted reset, `ry_by` is the inverse of `eng_busy`. After a reset accepted while busy, `ry_by` is 0 for T_READY_BUSY cycles after the accepting edge, whatever `eng_busy` does. It becomes 1 after the T_READY_BUSY-th edge that follows.
- R5: After a reset accepted while idle, `ry_by` stays 1 for the whole reset. The internal reset completes T_READY_IDLE edges after the accepting edge.
- R6: Counting from the accepting edge, commands reopen no earlier than edge T_READY+1. T_READY is T_READY_BUSY or T_READY_IDLE, depending on the case.
- R7: Commands reopen at the T_RH-th consecutive edge that samples `mem_rst_n` high inside an accepted reset. A low sample during recovery restarts this count.
- R8: `force_rd` is 1 from the accepting edge until the edge at which commands reopen, and 0 otherwise, including directly after the system reset `rst_n`.
- R9: While commands are accepted (`cmd_accept` = 1), `dq_oe` follows `rd_req` and `cmd_we` follows `wr_req`, each on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, asynchronous, active low |
| mem_rst_n | input | 1 | Device reset pin, active low, synchronous to clk |
| eng_busy | input | 1 | Embedded program/erase engine is running |
| rd_req | input | 1 | Host read strobe |
| wr_req | input | 1 | Host write strobe |
| ry_by | output | 1 | Ready (1) / busy (0) indication |
| dq_oe | output | 1 | Data pin output enable |
| cmd_we | output | 1 | Write strobe passed on to the command decoder |
| cmd_accept | output | 1 | Command path open |
| force_rd | output | 1 | Hold command decoder in array-read mode |
| op_aborted | output | 1 | One-cycle pulse: an embedded operation was aborted |

## Verification
The hardest case to reach is the interplay of the two reopening conditions. The ready timer and the recovery count finish in either order, depending on how long the pin stays low. The stimulus sweeps the low-pulse length from one cycle up to beyond T_RP+T_READY_BUSY, for both busy and idle starts, and computes the reopening edge as the later of the two limits. A further sequence drops the pin for one cycle in the middle of recovery, to show that the recovery count restarts.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic {
    SQ_RUN = 1'b0,
    SQ_RST = 1'b1
  } sq_state_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/mrs_pulse_qual.sv
module mrs_pulse_qual #(
  parameter int unsigned T_RP = 4,
  parameter int unsigned W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_low,
  input  logic clr,
  output logic valid
);
  localparam logic [W-1:0] LastCnt = W'(T_RP - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    valid  = pin_low && (cnt_q == LastCnt);
    cnt_en = 1'b1;
    if (clr || !pin_low) begin
      cnt_d = '0;
    end else if (cnt_q == LastCnt) begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  p_qual_bound_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LastCnt);
  p_qual_clears_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    !pin_low |=> (cnt_q == '0));
endmodule

// File: rtl/mrs_ready_timer.sv
module mrs_ready_timer #(
  parameter int unsigned T_BUSY = 12,
  parameter int unsigned T_IDLE = 5,
  parameter int unsigned W      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_busy,
  input  logic run,
  output logic done,
  output logic was_busy
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] target;
  logic         cnt_en;
  logic         busy_q;

  always_comb begin
    target = busy_q ? W'(T_BUSY) : W'(T_IDLE);
    done   = (cnt_q >= target);
    cnt_en = start || (run && !done);
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      if (start) begin
        busy_q <= start_busy;
      end
    end
  end

  assign was_busy = busy_q;

  p_timer_bound_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= target);
  p_timer_fresh_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

// File: rtl/mrs_recover_timer.sv
module mrs_recover_timer #(
  parameter int unsigned T_RH = 3,
  parameter int unsigned W    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_high,
  input  logic run,
  output logic ok
);
  localparam logic [W-1:0] LastCnt = W'(T_RH - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    ok     = pin_high && (cnt_q == LastCnt);
    cnt_en = 1'b1;
    if (!run || !pin_high) begin
      cnt_d = '0;
    end else if (cnt_q == LastCnt) begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  p_recover_restart_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pin_high) |=> (cnt_q == '0));
  p_recover_bound_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LastCnt);
endmodule

// File: rtl/mem_rst_seq.sv
module mem_rst_seq
  import mrs_pkg::*;
#(
  parameter int unsigned T_RP         = 4,
  parameter int unsigned T_READY_BUSY = 12,
  parameter int unsigned T_READY_IDLE = 5,
  parameter int unsigned T_RH         = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_rst_n,
  input  logic eng_busy,
  input  logic rd_req,
  input  logic wr_req,
  output logic ry_by,
  output logic dq_oe,
  output logic cmd_we,
  output logic cmd_accept,
  output logic force_rd,
  output logic op_aborted
);
  localparam int unsigned RdyMax = (T_READY_BUSY > T_READY_IDLE) ? T_READY_BUSY : T_READY_IDLE;
  localparam int unsigned QualW  = cnt_width(T_RP);
  localparam int unsigned RdyW   = cnt_width(RdyMax);
  localparam int unsigned RecW   = cnt_width(T_RH);

  sq_state_e st_q, st_d;
  logic      in_rst;
  logic      entry, leave;
  logic      qual_valid;
  logic      rdy_done, rdy_busy;
  logic      rec_ok;
  logic      abort_q, abort_d;

  assign in_rst = (st_q == SQ_RST);

  mrs_pulse_qual #(.T_RP(T_RP), .W(QualW)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_low (!mem_rst_n),
    .clr     (in_rst),
    .valid   (qual_valid)
  );

  mrs_ready_timer #(.T_BUSY(T_READY_BUSY), .T_IDLE(T_READY_IDLE), .W(RdyW)) u_ready (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (entry),
    .start_busy (eng_busy),
    .run        (in_rst),
    .done       (rdy_done),
    .was_busy   (rdy_busy)
  );

  mrs_recover_timer #(.T_RH(T_RH), .W(RecW)) u_recover (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_high (mem_rst_n),
    .run      (in_rst),
    .ok       (rec_ok)
  );

  always_comb begin
    entry   = !in_rst && qual_valid;
    leave   = in_rst && rdy_done && rec_ok;
    abort_d = entry && eng_busy;
    st_d    = st_q;
    if (entry) begin
      st_d = SQ_RST;
    end else if (leave) begin
      st_d = SQ_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_RUN;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= abort_d;
    end
  end

  always_comb begin
    cmd_accept = !in_rst && mem_rst_n;
    dq_oe      = cmd_accept && rd_req;
    cmd_we     = cmd_accept && wr_req;
    force_rd   = in_rst;
    op_aborted = abort_q;
    if (in_rst) begin
      ry_by = !rdy_busy || rdy_done;
    end else begin
      ry_by = !eng_busy;
    end
  end

  p_entry_qualified_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_rst) |-> $past(!mem_rst_n));
  p_gate_closed_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rst_n |-> (!dq_oe && !cmd_we));
  p_abort_single_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    op_aborted |=> !op_aborted);
  p_abort_on_entry_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    op_aborted |-> (in_rst && $past(eng_busy) && $past(!in_rst)));
  p_reopen_high_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rst) |-> $past(mem_rst_n));
  p_reopen_ready_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rst) |-> $past(rdy_done));
endmodule

// File: tb/tb_mem_rst_seq.sv
module tb_mem_rst_seq;
  localparam int TRP = 4;
  localparam int TRB = 12;
  localparam int TRI = 5;
  localparam int TRH = 3;

  logic clk = 1'b0;
  logic rst_n, mem_rst_n, eng_busy, rd_req, wr_req;
  logic ry_by, dq_oe, cmd_we, cmd_accept, force_rd, op_aborted;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mem_rst_seq #(
    .T_RP(TRP), .T_READY_BUSY(TRB), .T_READY_IDLE(TRI), .T_RH(TRH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mem_rst_n(mem_rst_n), .eng_busy(eng_busy),
    .rd_req(rd_req), .wr_req(wr_req), .ry_by(ry_by), .dq_oe(dq_oe),
    .cmd_we(cmd_we), .cmd_accept(cmd_accept), .force_rd(force_rd),
    .op_aborted(op_aborted)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic scen(input int low_len, input bit busy);
    bit accepted;
    int trdy;
    int exit_t;
    bit acc;
    logic ry_exp;
    accepted = (low_len >= TRP);
    trdy     = busy ? TRB : TRI;
    eng_busy = busy;
    rd_req   = 1'b1;
    wr_req   = 1'b1;
    tick();
    chk("R4", "ry_by before reset", ry_by, !busy);
    chk("R9", "dq_oe before reset", dq_oe, 1'b1);
    mem_rst_n = 1'b0;
    for (int t = 1; t <= low_len; t++) begin
      tick();
      chk("R2", "dq_oe while low", dq_oe, 1'b0);
      chk("R2", "cmd_we while low", cmd_we, 1'b0);
      chk("R2", "cmd_accept while low", cmd_accept, 1'b0);
      chk("R8", "force_rd while low", force_rd, (t >= TRP) ? 1'b1 : 1'b0);
      chk("R3", "op_aborted while low", op_aborted, (busy && t == TRP) ? 1'b1 : 1'b0);
      if (t >= TRP) ry_exp = busy ? ((t - TRP) >= TRB) : 1'b1;
      else          ry_exp = !eng_busy;
      chk(busy ? "R4" : "R5", "ry_by while low", ry_by, ry_exp);
      if (busy && t == TRP + 1) eng_busy = 1'b0;
    end
    mem_rst_n = 1'b1;
    if (!accepted) begin
      tick();
      chk("R1", "force_rd after short pulse", force_rd, 1'b0);
      chk("R1", "cmd_accept after short pulse", cmd_accept, 1'b1);
      chk("R1", "ry_by after short pulse", ry_by, !busy);
      chk("R1", "op_aborted after short pulse", op_aborted, 1'b0);
    end else begin
      exit_t = TRP + trdy + 1;
      if (low_len + TRH > exit_t) exit_t = low_len + TRH;
      for (int t = low_len + 1; t <= exit_t + 1; t++) begin
        tick();
        acc = (t >= exit_t);
        chk((exit_t == low_len + TRH) ? "R7" : "R6", "cmd_accept reopen", cmd_accept, acc);
        chk("R9", "dq_oe reopen", dq_oe, acc);
        chk("R9", "cmd_we reopen", cmd_we, acc);
        chk("R8", "force_rd recovery", force_rd, !acc);
        chk("R3", "op_aborted recovery", op_aborted, (busy && t == TRP) ? 1'b1 : 1'b0);
        if (!acc) ry_exp = busy ? ((t - TRP) >= TRB) : 1'b1;
        else      ry_exp = !eng_busy;
        chk(busy ? "R4" : "R5", "ry_by recovery", ry_by, ry_exp);
        if (busy && t == TRP + 1) eng_busy = 1'b0;
      end
    end
    eng_busy = 1'b0;
    tick();
  endtask

  initial begin
    rst_n = 1'b0; mem_rst_n = 1'b1; eng_busy = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R8", "force_rd after system reset", force_rd, 1'b0);
    chk("R6", "cmd_accept after system reset", cmd_accept, 1'b1);
    chk("R4", "ry_by after system reset", ry_by, 1'b1);
    chk("R3", "op_aborted after system reset", op_aborted, 1'b0);

    // R9: independent read and write gating
    rd_req = 1'b1; wr_req = 1'b0; tick();
    chk("R9", "dq_oe read only", dq_oe, 1'b1);
    chk("R9", "cmd_we read only", cmd_we, 1'b0);
    rd_req = 1'b0; wr_req = 1'b1; tick();
    chk("R9", "dq_oe write only", dq_oe, 1'b0);
    chk("R9", "cmd_we write only", cmd_we, 1'b1);

    // Sweep of pulse lengths for busy and idle starts (R1..R8)
    for (int b = 0; b < 2; b++) begin
      for (int len = 1; len <= TRP + TRB + TRH + 3; len++) begin
        scen(len, b[0]);
      end
    end

    // R7: a low sample during recovery restarts the recovery count
    rd_req = 1'b1; wr_req = 1'b0;
    mem_rst_n = 1'b0;
    repeat (TRP + TRB + 4) tick();
    mem_rst_n = 1'b1;
    for (int k = 1; k < TRH; k++) begin
      tick();
      chk("R7", "cmd_accept before glitch", cmd_accept, 1'b0);
    end
    mem_rst_n = 1'b0;
    tick();
    chk("R7", "cmd_accept during glitch", cmd_accept, 1'b0);
    chk("R8", "force_rd during glitch", force_rd, 1'b1);
    mem_rst_n = 1'b1;
    for (int k = 1; k <= TRH; k++) begin
      tick();
      chk("R7", "cmd_accept after glitch", cmd_accept, (k == TRH) ? 1'b1 : 1'b0);
      chk("R7", "dq_oe after glitch", dq_oe, (k == TRH) ? 1'b1 : 1'b0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule